// File: doc/BRIEF.md
# Interrupt Polarity Normalizer

This block conditions a bank of wake-capable interrupt lines for a downstream interrupt controller that understands only two kinds of input: an active-high level and a rising edge. Every line is first brought into the local clock domain by a two-flop synchronizer. A per-pin trigger code then decides how it is seen. Active-low and falling-edge lines pass through an inverter. Dual-edge lines yield an event on every transition. Edge-type lines produce a single-cycle pulse. Level-type lines produce a steady active-high level.

Software reaches three banks through a word-addressed register port. The enable bank packs 32 pins into each word. The trigger bank holds one word per pin. The event-flag bank also packs 32 pins into each word and is cleared by writing ones. The event flag lets software remove the spurious edge that appears when a pin's trigger code is rewritten while its input holds still. A wake request is raised whenever any pin is active and is held until it is acknowledged.

Top module: `irqnorm_top`

## Requirements
- R1: Level modes. Code 3'b100 (level high) passes the synchronized input. Code 3'b000 (level low) inverts it. `irq_out[p]` follows the enabled, normalized level. An input change driven before clock edge k appears at `irq_out` after edge k+2.
- R2: Single-edge modes. Code 3'b110 (rising) and code 3'b010 (falling, inverted first) give a `irq_out[p]` pulse exactly one cycle wide, on the normalized rising transition only.
- R3: Code 3'b111 (both edges) gives a one-cycle `irq_out[p]` pulse on every input transition, rising or falling.
- R4: Pin p's enable is bit p%32 of word index 4 + p/32 (byte offset 0x10). Enable bits beyond the pin count read as zero. While a pin is disabled, its `irq_out` never asserts and its event flag is not set.
- R5: Pin p's trigger code is bits [2:0] of word index 0x44 + p (byte offset 0x110 + 4*p). It reads back with all upper bits zero, and the upper write bits are ignored.
- R6: A write carrying an unused code (3'b001, 3'b011, 3'b101) is ignored. The previous code stays in place, and so does the pin's behaviour.
- R7: Pin p's event flag is bit p%32 of word index 0x100 + p/32. The flag is set together with every edge pulse of an enabled pin. Writing a one clears it and writing a zero leaves it alone. A new event in the same cycle as a clear wins.
- R8: Rewriting a pin's trigger code so that its normalized value flips while the input is steady gives one edge pulse and sets the event flag. Software can then clear that flag.
- R9: Reset clears all enables and event flags, drives every output low, and sets every trigger code to level high (3'b100).
- R10: `wake_req` rises the cycle after any `irq_out` bit or event flag is set. It stays high until `wake_ack` is seen while nothing is active, and falls on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NPINS | Raw interrupt lines, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| irq_out | output | NPINS | Normalized active-high level or rising pulse per pin |
| wake_req | output | 1 | Wake request to the power controller |
| wake_ack | input | 1 | Wake acknowledge |

## Verification
The properties assume that every `irq_in` level lasts at least two clocks. Shorter glitches may vanish in the synchronizer, and the edge checks do not cover them. They also assume that `wake_ack` is a level the controller raises only after it has seen `wake_req`. The stimulus changes inputs and register writes only at falling clock edges. It holds each input value for at least five cycles. It raises `wake_ack` only once every pin is quiet and all event flags have been cleared.

// File: rtl/irqnorm_pkg.sv
`timescale 1ns/1ps
package irqnorm_pkg;

    typedef enum logic [2:0] {
        TRIG_LVL_LO = 3'b000,
        TRIG_FALL   = 3'b010,
        TRIG_LVL_HI = 3'b100,
        TRIG_RISE   = 3'b110,
        TRIG_BOTH   = 3'b111
    } trig_e;

    // Register map, word indices
    localparam int unsigned REG_WORD_W    = 32;
    localparam int unsigned MAP_EN_WORD   = 'h004;
    localparam int unsigned MAP_TYPE_WORD = 'h044;
    localparam int unsigned MAP_PEND_WORD = 'h100;

    function automatic logic trig_legal(input logic [2:0] code);
        return (code == TRIG_LVL_LO) || (code == TRIG_FALL) ||
               (code == TRIG_LVL_HI) || (code == TRIG_RISE) ||
               (code == TRIG_BOTH);
    endfunction

    // bit 2 clear: source is active-low / falling
    function automatic logic trig_invert(input logic [2:0] code);
        return ~code[2];
    endfunction

    function automatic logic trig_is_edge(input logic [2:0] code);
        return code[1];
    endfunction

    function automatic logic trig_is_dual(input logic [2:0] code);
        return code[0];
    endfunction

endpackage

// File: rtl/irqnorm_sync.sv
`timescale 1ns/1ps
module irqnorm_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_i;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.stable;

endmodule

// File: rtl/irqnorm_regs.sv
`timescale 1ns/1ps
module irqnorm_regs
    import irqnorm_pkg::*;
#(
    parameter int unsigned NPINS  = 168,
    parameter int unsigned ADDR_W = 10
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    input  logic [NPINS-1:0]      pend_i,
    output logic [31:0]           rdata,
    output logic [NPINS-1:0]      en_o,
    output logic [NPINS-1:0][2:0] typ_o,
    output logic [NPINS-1:0]      clr_o
);

    typedef struct packed {
        logic [NPINS-1:0]      en;
        logic [NPINS-1:0][2:0] typ;
    } cfg_t;

    cfg_t        cfg_d, cfg_q;
    int unsigned aw;

    assign aw = 32'(addr);

    always_comb begin
        cfg_d = cfg_q;
        clr_o = '0;
        if (we) begin
            for (int p = 0; p < NPINS; p++) begin
                if (aw == MAP_EN_WORD + p / REG_WORD_W)
                    cfg_d.en[p] = wdata[p % REG_WORD_W];
                if (aw == MAP_PEND_WORD + p / REG_WORD_W)
                    clr_o[p] = wdata[p % REG_WORD_W];
                if ((aw == MAP_TYPE_WORD + p) && trig_legal(wdata[2:0]))
                    cfg_d.typ[p] = wdata[2:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        for (int p = 0; p < NPINS; p++) begin
            if (aw == MAP_EN_WORD + p / REG_WORD_W)
                rdata[p % REG_WORD_W] = cfg_q.en[p];
            if (aw == MAP_PEND_WORD + p / REG_WORD_W)
                rdata[p % REG_WORD_W] = pend_i[p];
            if (aw == MAP_TYPE_WORD + p)
                rdata[2:0] = cfg_q.typ[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.en <= '0;
            for (int p = 0; p < NPINS; p++) cfg_q.typ[p] <= TRIG_LVL_HI;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o  = cfg_q.en;
    assign typ_o = cfg_q.typ;

endmodule

// File: rtl/irqnorm_cond.sv
`timescale 1ns/1ps
module irqnorm_cond
    import irqnorm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sig_i,
    input  logic       en_i,
    input  logic [2:0] typ_i,
    input  logic       clr_i,
    output logic       out_o,
    output logic       pend_o
);

    typedef struct packed {
        logic nprev;
        logic out;
        logic pend;
    } cond_t;

    cond_t st_d, st_q;
    logic  norm;
    logic  evt;

    always_comb begin
        norm = sig_i ^ trig_invert(typ_i);
        if (trig_is_dual(typ_i)) evt = norm ^ st_q.nprev;
        else                     evt = norm & ~st_q.nprev;

        st_d.nprev = norm;
        st_d.out   = en_i & (trig_is_edge(typ_i) ? evt : norm);
        st_d.pend  = (st_q.pend & ~clr_i) | (en_i & trig_is_edge(typ_i) & evt);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_o  = st_q.out;
    assign pend_o = st_q.pend;

endmodule

// File: rtl/irqnorm_top.sv
`timescale 1ns/1ps
module irqnorm_top
    import irqnorm_pkg::*;
#(
    parameter int unsigned NPINS  = 168,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  irq_in,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic [NPINS-1:0]  irq_out,
    output logic              wake_req,
    input  logic              wake_ack
);

    typedef struct packed {
        logic req;
    } wake_t;

    logic [NPINS-1:0]      sync_sig;
    logic [NPINS-1:0]      pin_en;
    logic [NPINS-1:0][2:0] pin_typ;
    logic [NPINS-1:0]      pin_clr;
    logic [NPINS-1:0]      pin_pend;
    wake_t                 wk_d, wk_q;

    irqnorm_sync #(.WIDTH(NPINS)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (irq_in),
        .sync_o  (sync_sig)
    );

    irqnorm_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (reg_we),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .pend_i (pin_pend),
        .rdata  (reg_rdata),
        .en_o   (pin_en),
        .typ_o  (pin_typ),
        .clr_o  (pin_clr)
    );

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        irqnorm_cond u_cond (
            .clk    (clk),
            .rst_n  (rst_n),
            .sig_i  (sync_sig[p]),
            .en_i   (pin_en[p]),
            .typ_i  (pin_typ[p]),
            .clr_i  (pin_clr[p]),
            .out_o  (irq_out[p]),
            .pend_o (pin_pend[p])
        );
    end

    always_comb begin
        wk_d.req = (|(irq_out | pin_pend)) | (wk_q.req & ~wake_ack);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wk_q <= '0;
        else        wk_q <= wk_d;
    end

    assign wake_req = wk_q.req;

endmodule

// File: rtl/irqnorm_chk.sv
`timescale 1ns/1ps
module irqnorm_chk #(
    parameter int unsigned NPINS = 168
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NPINS-1:0]      irq_out,
    input logic                  wake_req,
    input logic                  wake_ack,
    input logic [NPINS-1:0]      pin_en,
    input logic [NPINS-1:0][2:0] pin_typ,
    input logic [NPINS-1:0]      pin_pend
);

    // R4: an output only asserts if the pin was enabled the cycle before
    a_r4_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out & ~$past(pin_en)) == '0);

    // R10: any active output raises the wake request next cycle
    a_r10_wake_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (|irq_out) |=> wake_req);

    // R10: request held until acknowledged
    a_r10_wake_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_req && !wake_ack) |=> wake_req);

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        // R2: single-edge pulse is one cycle wide while the code is stable
        a_r2_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[p] && pin_typ[p][1] && !pin_typ[p][0] &&
             pin_typ[p] == $past(pin_typ[p])) |=> !irq_out[p]);

        // R7: every edge pulse comes with its event flag
        a_r7_flag_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
            (irq_out[p] && $past(pin_typ[p][1])) |-> pin_pend[p]);
    end

    // R6: stored trigger codes are always one of the five legal values
    always @(posedge clk) begin
        if (rst_n) begin
            for (int p = 0; p < NPINS; p++) begin
                a_r6_code_legal: assert (pin_typ[p] == 3'b000 || pin_typ[p] == 3'b010 ||
                                         pin_typ[p] == 3'b100 || pin_typ[p] == 3'b110 ||
                                         pin_typ[p] == 3'b111)
                    else $error("illegal trigger code on pin %0d", p);
            end
        end
    end

endmodule

bind irqnorm_top irqnorm_chk #(.NPINS(NPINS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_out  (irq_out),
    .wake_req (wake_req),
    .wake_ack (wake_ack),
    .pin_en   (pin_en),
    .pin_typ  (pin_typ),
    .pin_pend (pin_pend)
);

// File: tb/tb_irqnorm_top.sv
`timescale 1ns/1ps
module tb_irqnorm_top;

    localparam int unsigned NP = 40;
    localparam int unsigned AW = 10;
    localparam int EN  = 'h004;
    localparam int TYP = 'h044;
    localparam int PND = 'h100;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] irq_in;
    logic          reg_we;
    logic [AW-1:0] reg_addr;
    logic [31:0]   reg_wdata;
    logic [31:0]   reg_rdata;
    logic [NP-1:0] irq_out;
    logic          wake_req;
    logic          wake_ack;

    irqnorm_top #(.NPINS(NP), .ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out), .wake_req(wake_req), .wake_ack(wake_ack)
    );

    always #2.5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int    at;
        int    kind;   // 0: irq_out bit, 1: wake_req
        int    pin;
        logic  val;
        string req;
    } item_t;

    item_t sb[$];
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    done  = 0;
    logic  act;

    // monitor: compares expectations that fall due this cycle
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].at == cyc) begin
                act = (sb[i].kind == 0) ? irq_out[sb[i].pin] : wake_req;
                n_cmp++;
                if (act !== sb[i].val) begin
                    n_bad++;
                    $display("FAIL %s kind %0d pin %0d cycle %0d: actual %b expected %b",
                             sb[i].req, sb[i].kind, sb[i].pin, cyc, act, sb[i].val);
                end
                sb.delete(i);
            end
        end
    end

    task automatic push(input int kind, input int pin, input int at, input logic val,
                        input string req);
        item_t it;
        it.at = at; it.kind = kind; it.pin = pin; it.val = val; it.req = req;
        sb.push_back(it);
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [31:0] d, output int c0);
        c0        = cyc;
        reg_we    = 1'b1;
        reg_addr  = AW'(a);
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic drv(input int p, input logic v, output int c0);
        c0        = cyc;
        irq_in[p] = v;
    endtask

    task automatic chk(input logic [31:0] a, input logic [31:0] e, input string req);
        n_cmp++;
        if (a !== e) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, a, e);
        end
    endtask

    task automatic rd(input int a, input logic [31:0] e, input string req);
        reg_addr = AW'(a);
        #1;
        chk(reg_rdata, e, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        int c;
        rst_n = 1'b0; irq_in = '0; reg_we = 1'b0; reg_addr = '0;
        reg_wdata = '0; wake_ack = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R9 reset state
        rd(EN, 32'h0, "R9");
        rd(EN + 1, 32'h0, "R9");
        rd(TYP, 32'h4, "R9");
        rd(TYP + 39, 32'h4, "R9");
        rd(PND, 32'h0, "R9");
        chk(32'(irq_out), 32'h0, "R9");
        chk(32'(wake_req), 32'h0, "R9");

        // R4 enable bank, bits past the pin count read zero
        wr(EN, 32'hFFFF_FFFF, c);
        wr(EN + 1, 32'hFFFF_FFFF, c);
        rd(EN, 32'hFFFF_FFFF, "R4");
        rd(EN + 1, 32'h0000_00FF, "R4");

        // R1 level high on pin 0, latency and R10 wake rise
        drv(0, 1'b1, c);
        push(0, 0, c + 2, 1'b0, "R1");
        push(0, 0, c + 3, 1'b1, "R1");
        push(1, 0, c + 3, 1'b0, "R10");
        push(1, 0, c + 4, 1'b1, "R10");
        tick(6);
        drv(0, 1'b0, c);
        push(0, 0, c + 3, 1'b0, "R1");
        tick(5);

        // R1 level low on pin 1 (input low -> active)
        wr(TYP + 1, 32'h0, c);
        push(0, 1, c + 1, 1'b0, "R1");
        push(0, 1, c + 2, 1'b1, "R1");
        tick(4);
        drv(1, 1'b1, c);
        push(0, 1, c + 2, 1'b1, "R1");
        push(0, 1, c + 3, 1'b0, "R1");
        tick(5);

        // R2 rising on pin 2
        wr(TYP + 2, 32'h6, c);
        push(0, 2, c + 2, 1'b0, "R2");
        push(0, 2, c + 3, 1'b0, "R2");
        tick(4);
        drv(2, 1'b1, c);
        push(0, 2, c + 2, 1'b0, "R2");
        push(0, 2, c + 3, 1'b1, "R2");
        push(0, 2, c + 4, 1'b0, "R2");
        tick(6);
        // R7 flag, zero write keeps it, one write clears it
        rd(PND, 32'h4, "R7");
        wr(PND, 32'h0, c);
        rd(PND, 32'h4, "R7");
        wr(PND, 32'h4, c);
        rd(PND, 32'h0, "R7");
        drv(2, 1'b0, c);
        push(0, 2, c + 3, 1'b0, "R2");
        push(0, 2, c + 4, 1'b0, "R2");
        tick(6);
        rd(PND, 32'h0, "R2");

        // R2 falling on pin 3, configured with input high
        drv(3, 1'b1, c);
        tick(5);
        wr(TYP + 3, 32'h2, c);
        push(0, 3, c + 2, 1'b0, "R2");
        push(0, 3, c + 3, 1'b0, "R2");
        tick(4);
        drv(3, 1'b0, c);
        push(0, 3, c + 3, 1'b1, "R2");
        push(0, 3, c + 4, 1'b0, "R2");
        tick(6);
        rd(TYP + 3, 32'h2, "R5");
        wr(PND, 32'h8, c);

        // R6 unused codes ignored, pin 2 still rising-edge
        wr(TYP + 2, 32'h5, c);
        rd(TYP + 2, 32'h6, "R6");
        wr(TYP + 2, 32'h1, c);
        wr(TYP + 2, 32'h3, c);
        rd(TYP + 2, 32'h6, "R6");
        drv(2, 1'b1, c);
        push(0, 2, c + 3, 1'b1, "R6");
        push(0, 2, c + 4, 1'b0, "R6");
        tick(6);
        drv(2, 1'b0, c);
        push(0, 2, c + 3, 1'b0, "R6");
        tick(6);
        wr(PND, 32'h4, c);

        // R5 upper write bits dropped, readback zero above bit 2
        wr(TYP + 5, 32'hABCD_EF06, c);
        rd(TYP + 5, 32'h6, "R5");

        // R3 both edges on pin 35 (second enable word)
        wr(TYP + 35, 32'h7, c);
        tick(3);
        drv(35, 1'b1, c);
        push(0, 35, c + 3, 1'b1, "R3");
        push(0, 35, c + 4, 1'b0, "R3");
        tick(6);
        drv(35, 1'b0, c);
        push(0, 35, c + 3, 1'b1, "R3");
        push(0, 35, c + 4, 1'b0, "R3");
        tick(6);
        rd(PND + 1, 32'h8, "R3");
        wr(PND + 1, 32'h8, c);
        rd(PND + 1, 32'h0, "R7");

        // R4 disabled pin stays quiet and sets no flag
        wr(EN + 1, 32'h0, c);
        rd(EN + 1, 32'h0, "R4");
        drv(35, 1'b1, c);
        push(0, 35, c + 3, 1'b0, "R4");
        push(0, 35, c + 4, 1'b0, "R4");
        tick(6);
        rd(PND + 1, 32'h0, "R4");

        // R8 polarity flip with steady low input on pin 4
        wr(TYP + 4, 32'h6, c);
        push(0, 4, c + 2, 1'b0, "R8");
        push(0, 4, c + 3, 1'b0, "R8");
        tick(4);
        wr(TYP + 4, 32'h2, c);
        push(0, 4, c + 2, 1'b1, "R8");
        push(0, 4, c + 3, 1'b0, "R8");
        tick(4);
        rd(PND, 32'h10, "R8");
        wr(PND, 32'h10, c);
        rd(PND, 32'h0, "R8");

        // R10 wake held until acknowledged while quiet
        wr(PND, 32'hFFFF_FFFF, c);
        wr(PND + 1, 32'hFFFF_FFFF, c);
        tick(3);
        chk(32'(irq_out), 32'h0, "R10");
        chk(32'(wake_req), 32'h1, "R10");
        c = cyc;
        wake_ack = 1'b1;
        push(1, 0, c + 1, 1'b0, "R10");
        tick(1);
        wake_ack = 1'b0;
        tick(3);
        chk(32'(wake_req), 32'h0, "R10");

        tick(4);
        chk(32'(sb.size()), 32'h0, "R10");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule